// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the address side of a multi-register load or store. After a start request it takes a word-aligned base address, a mask with one bit per register, a direction mode and a writeback flag. From these it produces the register index and word address for each transfer, one pair per cycle. A ready input paces the sequence, and a data mover (not part of this block) carries out each access while `valid` and `ready` are both high.

Registers are always visited from the lowest set mask bit to the highest, and addresses always rise by one word per transfer. The direction mode only moves the window of addresses relative to the base. A counting mode places the window at or just above the base. A decrementing mode places it just below the base. On the final transfer the block pulses `done`. With that same pulse it presents the updated base, one window length above or below the original base, and a write strobe for it when writeback was requested.

Top module: `multi_xfer_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, `valid`, `done` and `base_wr` are low.
- R2: Register indices come out in ascending order of mask bit position, one for each set bit. Each index is consumed on a cycle where `valid` and `ready` are both high.
- R3: With n set mask bits, the first address depends on `mode`. Mode 0 (count up, step after) starts at base. Mode 1 (count up, step before) starts at base+4. Mode 2 (count down, step after) starts at base-4n+4. Mode 3 (count down, step before) starts at base-4n. All arithmetic wraps modulo 2^AW.
- R4: Each address after the first in a sequence is the previous address plus 4.
- R5: While `valid` is high and `ready` is low, `valid`, `addr` and `reg_idx` hold their values.
- R6: `done` is high in exactly the cycle of the final accepted transfer. `valid` is low in the cycle after it.
- R7: With `done`, `new_base` equals base+4n in modes 0 and 1 and base-4n in modes 2 and 3.
- R8: `base_wr` is high exactly when `done` is high and the writeback flag was set at start.
- R9: A start with an all-zero mask gives `done` in the following cycle with `valid` low, no transfers, and `new_base` equal to base.
- R10: A start request while `valid` is high is ignored, and the sequence in progress continues unchanged.
- R11: A mask with all 16 bits set is accepted and produces 16 transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a sequence; taken only while idle |
| base | input | AW | Base word address |
| mask | input | NREG | Register selection, bit i selects register i |
| mode | input | 2 | 0 up/after, 1 up/before, 2 down/after, 3 down/before |
| wb_en | input | 1 | Request writeback of the updated base |
| ready | input | 1 | Consumer accepts the current transfer |
| reg_idx | output | IDXW | Register index of the current transfer |
| addr | output | AW | Word address of the current transfer |
| valid | output | 1 | A transfer is presented |
| done | output | 1 | Sequence finishes this cycle |
| new_base | output | AW | Updated base, meaningful with `done` |
| base_wr | output | 1 | Write strobe for `new_base` |

## Verification
The hardest case to reach is a second start request that arrives mid-sequence while the consumer is stalling. A run can end early or restart only in that window. The stimulus drives `ready` from a pseudo-random pattern and pulses `start` two cycles into a long sequence, using a different mask and mode. The scoreboard, which holds only the expected items of the first request, then shows that no stray transfer appears. Decrementing windows are also placed at base zero so that the address wraps.

// File: rtl/multi_xfer_pkg.sv
package multi_xfer_pkg;

  typedef enum logic [1:0] {
    MX_UP_POST = 2'd0,
    MX_UP_PRE  = 2'd1,
    MX_DN_POST = 2'd2,
    MX_DN_PRE  = 2'd3
  } mx_mode_e;

  function automatic logic mx_is_down(mx_mode_e m);
    return m[1];
  endfunction

  function automatic logic mx_is_pre(mx_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/mxs_rst_sync.sv
module mxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/mxs_popcount.sv
module mxs_popcount #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] part [W+1];

  assign part[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_acc
    assign part[g+1] = part[g] + CW'(vec[g]);
  end
  assign cnt = part[W];
endmodule

// File: rtl/mxs_pick_low.sv
module mxs_pick_low #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  low_oh,
  output logic          single
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign low_oh = vec & (~vec + W'(1));
  assign single = (vec & (vec - W'(1))) == '0;
endmodule

// File: rtl/mxs_window.sv
module mxs_window
  import multi_xfer_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 5,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] cnt,
  input  mx_mode_e      mode,
  output logic [AW-1:0] first,
  output logic [AW-1:0] nbase
);
  logic [AW-1:0] span;
  logic [AW-1:0] below;

  assign span  = AW'(cnt) * AW'(STEP);
  assign below = base - span;

  always_comb begin
    if (mx_is_down(mode)) begin
      first = mx_is_pre(mode) ? below : below + AW'(STEP);
      nbase = below;
    end else begin
      first = mx_is_pre(mode) ? base + AW'(STEP) : base;
      nbase = base + span;
    end
  end
endmodule

// File: rtl/multi_xfer_seq.sv
module multi_xfer_seq
  import multi_xfer_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int STEP = 4,
  localparam int IDXW = $clog2(NREG),
  localparam int CW   = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base,
  input  logic [NREG-1:0] mask,
  input  logic [1:0]      mode,
  input  logic            wb_en,
  input  logic            ready,
  output logic [IDXW-1:0] reg_idx,
  output logic [AW-1:0]   addr,
  output logic            valid,
  output logic            done,
  output logic [AW-1:0]   new_base,
  output logic            base_wr
);
  logic rst_s_n;

  mxs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_s_n(rst_s_n)
  );

  logic [CW-1:0] sel_cnt;
  mxs_popcount #(.W(NREG), .CW(CW)) u_cnt (
    .vec(mask),
    .cnt(sel_cnt)
  );

  logic [AW-1:0] win_first, win_nbase;
  mxs_window #(.AW(AW), .CW(CW), .STEP(STEP)) u_win (
    .base (base),
    .cnt  (sel_cnt),
    .mode (mx_mode_e'(mode)),
    .first(win_first),
    .nbase(win_nbase)
  );

  // sequence state
  logic [NREG-1:0] rem_q, rem_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [AW-1:0]   nb_q, nb_d;
  logic            valid_q, valid_d;
  logic            wb_q, wb_d;
  logic            zdone_q, zdone_d;

  logic [IDXW-1:0] cur_idx;
  logic [NREG-1:0] cur_oh;
  logic            cur_last;
  mxs_pick_low #(.W(NREG), .IW(IDXW)) u_pick (
    .vec   (rem_q),
    .idx   (cur_idx),
    .low_oh(cur_oh),
    .single(cur_last)
  );

  logic take, accept_start, seq_end;
  assign take         = valid_q & ready;
  assign accept_start = start & ~valid_q;
  assign seq_end      = take & cur_last;

  always_comb begin
    rem_d   = rem_q;
    addr_d  = addr_q;
    nb_d    = nb_q;
    valid_d = valid_q;
    wb_d    = wb_q;
    zdone_d = 1'b0;
    if (valid_q) begin
      if (ready) begin
        rem_d   = rem_q & ~cur_oh;
        addr_d  = addr_q + AW'(STEP);
        valid_d = ~cur_last;
      end
    end else if (accept_start) begin
      rem_d   = mask;
      addr_d  = win_first;
      nb_d    = win_nbase;
      wb_d    = wb_en;
      valid_d = |mask;
      zdone_d = ~(|mask);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rem_q   <= '0;
      addr_q  <= '0;
      nb_q    <= '0;
      valid_q <= 1'b0;
      wb_q    <= 1'b0;
      zdone_q <= 1'b0;
    end else begin
      rem_q   <= rem_d;
      addr_q  <= addr_d;
      nb_q    <= nb_d;
      valid_q <= valid_d;
      wb_q    <= wb_d;
      zdone_q <= zdone_d;
    end
  end

  assign reg_idx  = cur_idx;
  assign addr     = addr_q;
  assign valid    = valid_q;
  assign done     = seq_end | zdone_q;
  assign new_base = nb_q;
  assign base_wr  = done & wb_q;

  // R5
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid && !ready |=> valid && $stable(addr) && $stable(reg_idx));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid && ready && !done |=> valid && addr == $past(addr) + AW'(STEP));

  // R2
  idx_rise_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid && ready && !done |=> reg_idx > $past(reg_idx));

  // R6
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid && ready && done |=> !valid);

  // R8
  wr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    base_wr |-> done);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid && start && !ready |=> $stable(addr) && $stable(new_base));
endmodule

// File: tb/sim_multi_xfer_seq.sv
module sim_multi_xfer_seq;
  localparam int AW = 32;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [NR-1:0] mask = '0;
  logic [1:0] mode = '0;
  logic wb_en = 1'b0;
  logic ready = 1'b1;
  logic [3:0] reg_idx;
  logic [AW-1:0] addr, new_base;
  logic valid, done, base_wr;

  always #10 clk = ~clk;

  multi_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .mask(mask),
    .mode(mode), .wb_en(wb_en), .ready(ready), .reg_idx(reg_idx),
    .addr(addr), .valid(valid), .done(done), .new_base(new_base),
    .base_wr(base_wr)
  );

  typedef struct {
    bit          zero;
    int          idx;
    logic [31:0] a;
    bit          last;
    bit          first;
    logic [31:0] nb;
    bit          wb;
  } exp_t;

  exp_t sb[$];
  int n_run = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit rdy_rand = 1'b0;
  bit summary_done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready pattern
  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    forever begin
      @(posedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ready = rdy_rand ? lf[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit pv, pr;
    logic [31:0] pa;
    logic [3:0] pi;
    pv = 0; pr = 1; pa = '0; pi = '0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (pv && !pr) begin
          chk("R5 valid held", 32'(valid), 32'd1);
          chk("R5 addr held", addr, pa);
          chk("R5 idx held", 32'(reg_idx), 32'(pi));
        end
        if (valid && ready) begin
          if (sb.size() == 0) begin
            n_run++; n_bad++;
            $display("FAIL R10 unexpected transfer actual=idx %0d expected=none", reg_idx);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk("R2 index", 32'(reg_idx), 32'(e.idx));
            chk(e.first ? "R3 first addr" : "R4 next addr", addr, e.a);
            chk("R6 done", 32'(done), 32'(e.last));
            chk("R8 base_wr", 32'(base_wr), 32'(e.last & e.wb));
            if (e.last) chk("R7 new_base", new_base, e.nb);
          end
        end else if (done) begin
          if (sb.size() == 0 || !sb[0].zero) begin
            n_run++; n_bad++;
            $display("FAIL R9 stray done actual=1 expected=0");
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk("R9 valid low", 32'(valid), 32'd0);
            chk("R9 new_base", new_base, e.nb);
            chk("R8 base_wr zero", 32'(base_wr), 32'(e.wb));
          end
        end
      end
      pv = valid; pr = ready; pa = addr; pi = reg_idx;
    end
  end

  task automatic run_op(logic [31:0] b, logic [15:0] m, logic [1:0] md, bit wb, bit poke);
    int n;
    int k;
    logic [31:0] lo, nb;
    n = $countones(m);
    case (md)
      2'd0: lo = b;
      2'd1: lo = b + 32'd4;
      2'd2: lo = b - 32'(4 * n) + 32'd4;
      default: lo = b - 32'(4 * n);
    endcase
    nb = md[1] ? b - 32'(4 * n) : b + 32'(4 * n);
    if (n == 0) begin
      exp_t z;
      z = '{zero: 1, idx: 0, a: 0, last: 1, first: 0, nb: b, wb: wb};
      sb.push_back(z);
    end
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        exp_t e;
        e = '{zero: 0, idx: i, a: lo + 32'(4 * k), last: (k == n - 1),
              first: (k == 0), nb: nb, wb: wb};
        sb.push_back(e);
        k++;
      end
    end
    base = b; mask = m; mode = md; wb_en = wb; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      @(posedge clk); #1;
      @(posedge clk); #1;
      // R10: request while busy
      base = 32'h0BAD_0000; mask = 16'h0003; mode = 2'd3; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (sb.size() != 0) begin
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", 32'(valid), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 valid idle", 32'(valid), 32'd0);
    chk("R1 done idle", 32'(done), 32'd0);
    chk("R1 base_wr idle", 32'(base_wr), 32'd0);
    mon_on = 1'b1;

    // R3 each mode, registers {0,2,5}
    run_op(32'h0000_1000, 16'h0025, 2'd0, 1'b1, 1'b0);
    run_op(32'h0000_1000, 16'h0025, 2'd1, 1'b1, 1'b0);
    run_op(32'h0000_1000, 16'h0025, 2'd2, 1'b0, 1'b0);
    run_op(32'h0000_1000, 16'h0025, 2'd3, 1'b1, 1'b0);
    // R11 full mask
    run_op(32'h2000_0040, 16'hFFFF, 2'd3, 1'b1, 1'b0);
    run_op(32'h2000_0040, 16'hFFFF, 2'd0, 1'b0, 1'b0);
    // single high register
    run_op(32'h0000_0800, 16'h8000, 2'd1, 1'b1, 1'b0);
    // wraparound below zero
    run_op(32'h0000_0000, 16'h0F0F, 2'd2, 1'b1, 1'b0);
    // R9 zero mask
    run_op(32'h0000_3000, 16'h0000, 2'd2, 1'b1, 1'b0);
    run_op(32'h0000_3000, 16'h0000, 2'd0, 1'b0, 1'b0);
    // R5 stalls, R10 start while busy
    rdy_rand = 1'b1;
    run_op(32'h4000_0100, 16'hA5A5, 2'd1, 1'b1, 1'b1);
    run_op(32'h4000_0100, 16'h7FFE, 2'd3, 1'b0, 1'b1);
    run_op(32'h0000_0010, 16'hFFFF, 2'd2, 1'b1, 1'b0);
    rdy_rand = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R6 idle after runs", 32'(valid), 32'd0);
    chk("R10 no leftover items", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule